// File: doc/BRIEF.md
# Interruption Priority and Status-Word Swap Unit

This unit arbitrates among five classes of interruption request: machine check, program, supervisor call, external and input/output. It holds the 64-bit current status word and uses that word's enable fields to decide which pending requests may be taken. It chooses the highest-ranked enabled request. It then runs a two-beat exchange on a doubleword memory port. The first beat writes the current word, with a class-specific code in its code field, to a fixed save slot for that class. The second beat reads a replacement word from the class's fixed fetch slot and makes it current.

Request inputs are levels. The requesting source holds its level until it sees its bit on the acknowledge vector, then drops it. Bits are numbered from the most significant end, so status bit n is vector bit 63-n. Instruction execution, the channels and real storage are outside this unit. The memory port is served by an external memory.

Top module: `intr_swap_unit`

## Requirements
- R1: After reset the status word equals the RESET_PSW parameter (default zero), `mem_req` is low and `int_ack` is zero.
- R2: When several requests are enabled together, the unit takes them in this order: machine check, program, supervisor call, external, I/O.
- R3: Status bit 13 enables machine check and status bit 7 enables external requests. An I/O request whose channel (upper byte of `io_dev`) is below 6 is enabled by the status bit with that channel's number. Channels 6 and above are enabled by status bit 6. Supervisor-call requests cannot be masked.
- R4: A program request with code 0x08, 0x0A, 0x0D or 0x0E is masked when status bit 36, 37, 38 or 39 respectively is 0. A masked program request of this kind is discarded. The unit makes no memory access, pulses `int_ack[1]` one cycle after sampling it, and leaves the status word unchanged. Program requests with any other code are never masked.
- R5: A request masked by a machine-check, external or I/O enable stays pending. It is taken, with no new edge on the request, once a loaded status word enables it.
- R6: A swap is a write beat followed by a read beat. The save/fetch byte addresses are: machine check 0x30/0x70, program 0x28/0x68, supervisor call 0x20/0x60, external 0x18/0x58, I/O 0x38/0x78.
- R7: The written word carries the interruption code in status bits 16-31 (vector bits 47:32). For machine check this is `mchk_code`. For program it is 0x00 followed by `pgm_code`. For supervisor call it is 0x00 followed by `svc_num`. For external it is 0x00 followed by `ext_lines`, where `ext_lines[7]` is the timer (code bit 24) and `ext_lines[6]` is the interrupt key (code bit 25). For I/O it is `io_dev`.
- R8: All other bits of the written word equal the current status word, including the instruction-length code (bits 32-33) and the condition code (bits 34-35).
- R9: Address, write enable and write data hold steady while `mem_req` is high and `mem_rdy` is low. Only one swap runs at a time, and requests are sampled only while idle. The cycle after the read beat completes, the status word holds the read data and `int_ack` shows a one-hot pulse naming the class taken (bit 0 machine check, 1 program, 2 supervisor call, 3 external, 4 I/O). The status word changes at no other time.
- R10: `wait_o` equals status bit 14. While it is set and no request is enabled, the unit makes no memory access. A swap that loads a word with bit 14 clear ends the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mchk_req | input | 1 | Machine-check request level |
| mchk_code | input | 16 | Code stored for machine check |
| pgm_req | input | 1 | Program-exception request level |
| pgm_code | input | 8 | Program exception number |
| svc_req | input | 1 | Supervisor-call request level |
| svc_num | input | 8 | Supervisor-call number |
| ext_lines | input | 8 | External sources; any bit set requests |
| io_req | input | 1 | I/O request level |
| io_dev | input | 16 | Device address, channel in upper byte |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | High for the write beat |
| mem_addr | output | ADDR_W | Doubleword byte address |
| mem_wdata | output | 64 | Saved status word |
| mem_rdy | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | 64 | Read data, valid with mem_rdy |
| psw_o | output | 64 | Current status word |
| wait_o | output | 1 | Wait-state bit of the current word |
| int_ack | output | 5 | One-hot class acknowledge pulse |

## Verification
On every cycle, the embedded properties check the memory-port discipline: beats stay stable until accepted, a write always opens a swap, and a read always follows the write. They also check that the status word never changes without an acknowledge, that acknowledges are one-hot, that the saved word keeps every field outside the code, and that the arbiter only ever names an enabled class. What the properties cannot show is decided by the bench scenarios. These are the absolute ranking of five simultaneous requests, the exact slot addresses and codes per class, the discard of masked program exceptions, requests held back by each enable field and later released by a newly loaded word, and the exit from wait through a supervisor call followed by a pending external request.

// File: rtl/intr_swap_pkg.sv
// Shared constants for the interruption swap unit.
// Assumes status bits are numbered from the most significant end
// (status bit n lives at vector index 63-n).
package intr_swap_pkg;

    localparam int NCLS     = 5;
    localparam int IX_MCHK  = 0;
    localparam int IX_PGM   = 1;
    localparam int IX_SVC   = 2;
    localparam int IX_EXT   = 3;
    localparam int IX_IO    = 4;

    localparam int SB_EXT_EN  = 7;
    localparam int SB_MCHK_EN = 13;
    localparam int SB_WAIT    = 14;
    localparam int SB_PMASK0  = 36;

    // Vector index of a status bit number.
    function automatic int vbit(int n);
        return 63 - n;
    endfunction

    // Save-slot byte address of a class.
    function automatic logic [7:0] save_slot(int cls);
        case (cls)
            IX_MCHK: return 8'h30;
            IX_PGM:  return 8'h28;
            IX_SVC:  return 8'h20;
            IX_EXT:  return 8'h18;
            default: return 8'h38;
        endcase
    endfunction

    // Fetch-slot byte address of a class (save slot plus 0x40).
    function automatic logic [7:0] fetch_slot(int cls);
        return save_slot(cls) + 8'h40;
    endfunction

endpackage

// File: rtl/intr_mask_filter.sv
// Applies the enable fields of the current status word to the raw
// request levels. Assumes requests are levels held by their sources.
// Produces the enabled vector and a flag for a program exception that
// its program-mask bit suppresses.
module intr_mask_filter
    import intr_swap_pkg::*;
#(
    parameter int CHAN_DIRECT = 6
) (
    input  logic [63:0]     psw,
    input  logic [NCLS-1:0] req,
    input  logic [7:0]      pgm_code,
    input  logic [7:0]      io_chan,
    output logic [NCLS-1:0] en,
    output logic            pgm_drop
);

    logic io_gate;
    logic pgm_masked;

    // Pick the channel enable: direct bit per low channel, shared bit above.
    always_comb begin
        io_gate = psw[vbit(CHAN_DIRECT)];
        for (int i = 0; i < CHAN_DIRECT; i++) begin
            if (io_chan == 8'(i)) io_gate = psw[vbit(i)];
        end
    end

    // Decide whether the program mask suppresses this exception number.
    always_comb begin
        case (pgm_code)
            8'h08:   pgm_masked = !psw[vbit(SB_PMASK0)];
            8'h0A:   pgm_masked = !psw[vbit(SB_PMASK0 + 1)];
            8'h0D:   pgm_masked = !psw[vbit(SB_PMASK0 + 2)];
            8'h0E:   pgm_masked = !psw[vbit(SB_PMASK0 + 3)];
            default: pgm_masked = 1'b0;
        endcase
    end

    // Gate each class with its enable field.
    always_comb begin
        en[IX_MCHK] = req[IX_MCHK] && psw[vbit(SB_MCHK_EN)];
        en[IX_PGM]  = req[IX_PGM] && !pgm_masked;
        en[IX_SVC]  = req[IX_SVC];
        en[IX_EXT]  = req[IX_EXT] && psw[vbit(SB_EXT_EN)];
        en[IX_IO]   = req[IX_IO] && io_gate;
        pgm_drop    = req[IX_PGM] && pgm_masked;
    end

endmodule

// File: rtl/intr_select.sv
// Fixed-rank arbiter over the enabled classes. Rank 0 (machine check)
// wins. A suppressed program exception competes at program rank and,
// when it wins, yields a discard instead of a swap.
module intr_select
    import intr_swap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] en,
    input  logic            pgm_drop,
    output logic [NCLS-1:0] sel,
    output logic            take,
    output logic            drop
);

    logic [NCLS-1:0] cand;
    logic            found;

    // Scan from highest rank and stop at the first candidate.
    always_comb begin
        cand = en;
        cand[IX_PGM] = en[IX_PGM] || pgm_drop;
        sel   = '0;
        take  = 1'b0;
        drop  = 1'b0;
        found = 1'b0;
        for (int i = 0; i < NCLS; i++) begin
            if (!found && cand[i]) begin
                found = 1'b1;
                if (i == IX_PGM && pgm_drop) begin
                    drop = 1'b1;
                end else begin
                    sel[i] = 1'b1;
                    take   = 1'b1;
                end
            end
        end
    end

    AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((sel & en) != '0) && $onehot(sel)); // R3
    AST_NO_HIGHER_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && en[IX_MCHK]) |-> sel[IX_MCHK]); // R2

endmodule

// File: rtl/intr_code_build.sv
// Forms the interruption code and the slot addresses of the selected
// class. Assumes sel is one-hot whenever its outputs are used.
module intr_code_build
    import intr_swap_pkg::*;
(
    input  logic [NCLS-1:0] sel,
    input  logic [15:0]     mchk_code,
    input  logic [7:0]      pgm_code,
    input  logic [7:0]      svc_num,
    input  logic [7:0]      ext_lines,
    input  logic [15:0]     io_dev,
    output logic [15:0]     code,
    output logic [7:0]      save_a,
    output logic [7:0]      fetch_a
);

    logic [15:0] cls_code [NCLS];

    // Per-class code sources.
    always_comb begin
        cls_code[IX_MCHK] = mchk_code;
        cls_code[IX_PGM]  = {8'h00, pgm_code};
        cls_code[IX_SVC]  = {8'h00, svc_num};
        cls_code[IX_EXT]  = {8'h00, ext_lines};
        cls_code[IX_IO]   = io_dev;
    end

    // AND-OR mux of code and slot addresses by the one-hot selection.
    always_comb begin
        code    = '0;
        save_a  = '0;
        fetch_a = '0;
        for (int i = 0; i < NCLS; i++) begin
            if (sel[i]) begin
                code    = code    | cls_code[i];
                save_a  = save_a  | save_slot(i);
                fetch_a = fetch_a | fetch_slot(i);
            end
        end
    end

endmodule

// File: rtl/intr_swap_unit.sv
// Top of the interruption swap unit. Holds the current status word,
// samples request levels while idle, and runs a write-then-read swap on
// a doubleword memory port with a ready handshake. Assumes the memory
// holds its response only for the cycle mem_rdy is high, and that each
// source drops its level on seeing its acknowledge bit.
module intr_swap_unit
    import intr_swap_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter logic [63:0] RESET_PSW   = 64'h0,
    parameter int          CHAN_DIRECT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mchk_req,
    input  logic [15:0]       mchk_code,
    input  logic              pgm_req,
    input  logic [7:0]        pgm_code,
    input  logic              svc_req,
    input  logic [7:0]        svc_num,
    input  logic [7:0]        ext_lines,
    input  logic              io_req,
    input  logic [15:0]       io_dev,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_rdy,
    input  logic [63:0]       mem_rdata,
    output logic [63:0]       psw_o,
    output logic              wait_o,
    output logic [NCLS-1:0]   int_ack
);

    localparam int PAD_W = ADDR_W - 8;

    typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_LOAD} st_e;

    st_e             state_q;
    logic [63:0]     psw_q;
    logic [NCLS-1:0] sel_q;
    logic [15:0]     code_q;
    logic [7:0]      save_q;
    logic [7:0]      fetch_q;
    logic [NCLS-1:0] ack_q;

    logic [NCLS-1:0] raw_req;
    logic [NCLS-1:0] en;
    logic            pgm_drop;
    logic [NCLS-1:0] sel;
    logic            take;
    logic            drop;
    logic [15:0]     code;
    logic [7:0]      save_a;
    logic [7:0]      fetch_a;

    // Collect the raw request levels in rank order.
    always_comb begin
        raw_req          = '0;
        raw_req[IX_MCHK] = mchk_req;
        raw_req[IX_PGM]  = pgm_req;
        raw_req[IX_SVC]  = svc_req;
        raw_req[IX_EXT]  = |ext_lines;
        raw_req[IX_IO]   = io_req;
    end

    intr_mask_filter #(.CHAN_DIRECT(CHAN_DIRECT)) u_filter (
        .psw      (psw_q),
        .req      (raw_req),
        .pgm_code (pgm_code),
        .io_chan  (io_dev[15:8]),
        .en       (en),
        .pgm_drop (pgm_drop)
    );

    intr_select u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .pgm_drop (pgm_drop),
        .sel      (sel),
        .take     (take),
        .drop     (drop)
    );

    intr_code_build u_code (
        .sel       (sel),
        .mchk_code (mchk_code),
        .pgm_code  (pgm_code),
        .svc_num   (svc_num),
        .ext_lines (ext_lines),
        .io_dev    (io_dev),
        .code      (code),
        .save_a    (save_a),
        .fetch_a   (fetch_a)
    );

    // Swap sequencer: idle sampling, store beat, load beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            psw_q   <= RESET_PSW;
            sel_q   <= '0;
            code_q  <= '0;
            save_q  <= '0;
            fetch_q <= '0;
            ack_q   <= '0;
        end else begin
            ack_q <= '0;
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        sel_q   <= sel;
                        code_q  <= code;
                        save_q  <= save_a;
                        fetch_q <= fetch_a;
                        state_q <= ST_STORE;
                    end else if (drop) begin
                        ack_q[IX_PGM] <= 1'b1;
                    end
                end
                ST_STORE: begin
                    if (mem_rdy) state_q <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (mem_rdy) begin
                        psw_q   <= mem_rdata;
                        ack_q   <= sel_q;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port from the sequencer state.
    always_comb begin
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_STORE);
        mem_addr  = {{PAD_W{1'b0}}, (state_q == ST_STORE) ? save_q : fetch_q};
        mem_wdata = {psw_q[63:48], code_q, psw_q[31:0]};
    end

    assign psw_o   = psw_q;
    assign wait_o  = psw_q[vbit(SB_WAIT)];
    assign int_ack = ack_q;

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(int_ack)); // R9
    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> mem_req && $stable(mem_addr)
            && $stable(mem_we) && $stable(mem_wdata)); // R9
    AST_STORE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> mem_we); // R6
    AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_rdy) |=> mem_req && !mem_we); // R6
    AST_PSW_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(psw_o) |-> (int_ack != '0)); // R9
    AST_FIELDS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[63:48] == psw_o[63:48])
            && (mem_wdata[31:0] == psw_o[31:0])); // R8

endmodule

// File: tb/intr_swap_unit_test.sv
// Scoreboard bench: driver tasks queue the expected memory beats and
// acknowledges; a negedge monitor serves memory and compares events.
module intr_swap_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mchk_req = 1'b0;
    logic [15:0] mchk_code = '0;
    logic        pgm_req = 1'b0;
    logic [7:0]  pgm_code = '0;
    logic        svc_req = 1'b0;
    logic [7:0]  svc_num = '0;
    logic [7:0]  ext_lines = '0;
    logic        io_req = 1'b0;
    logic [15:0] io_dev = '0;
    logic        mem_req;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_rdy = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [63:0] psw_o;
    logic        wait_o;
    logic [4:0]  int_ack;

    always #4 clk = ~clk;

    intr_swap_unit uut (
        .clk(clk), .rst_n(rst_n),
        .mchk_req(mchk_req), .mchk_code(mchk_code),
        .pgm_req(pgm_req), .pgm_code(pgm_code),
        .svc_req(svc_req), .svc_num(svc_num),
        .ext_lines(ext_lines),
        .io_req(io_req), .io_dev(io_dev),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
        .psw_o(psw_o), .wait_o(wait_o), .int_ack(int_ack)
    );

    typedef struct {
        int          kind;   // 0 write beat, 1 read beat, 2 acknowledge
        logic [23:0] addr;
        logic [63:0] data;
        logic [4:0]  ack;
        string       rq;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          failures = 0;
    int          lat = 0;
    int          lat_cnt = 0;
    logic [63:0] mem_model [32];
    logic [63:0] exp_psw = 64'h0;

    function automatic logic [63:0] sbit(int n);
        return 64'h1 << (63 - n);
    endfunction

    function automatic logic [7:0] slot_save(int c);
        case (c)
            0: return 8'h30;
            1: return 8'h28;
            2: return 8'h20;
            3: return 8'h18;
            default: return 8'h38;
        endcase
    endfunction

    task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Queue one full swap of class c with the given code.
    task automatic expect_swap(int c, logic [15:0] code, string rq);
        exp_t e;
        logic [7:0] sa;
        sa = slot_save(c);
        e.rq = rq; e.ack = '0;
        e.kind = 0; e.addr = {16'h0, sa};
        e.data = {exp_psw[63:48], code, exp_psw[31:0]};
        sb.push_back(e);
        e.kind = 1; e.addr = {16'h0, sa + 8'h40}; e.data = '0;
        sb.push_back(e);
        exp_psw = mem_model[(sa + 8'h40) >> 3];
        e.kind = 2; e.addr = '0; e.data = exp_psw; e.ack = 5'b1 << c;
        sb.push_back(e);
    endtask

    // Queue a discarded program exception.
    task automatic expect_drop(string rq);
        exp_t e;
        e.kind = 2; e.addr = '0; e.data = exp_psw; e.ack = 5'b00010; e.rq = rq;
        sb.push_back(e);
    endtask

    task automatic settle();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic idle_window(int n, string rq);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mem_req) seen++;
        end
        chk(seen == 0, rq, 64'(seen), 64'd0);
    endtask

    // Monitor and memory model: serve beats, compare against the queue.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && mem_req) begin
            if (lat_cnt >= lat) begin
                lat_cnt = 0;
                mem_rdy = 1'b1;
                if (sb.size() == 0) begin
                    chk(1'b0, "R10 unexpected beat", {40'h0, mem_addr}, 64'h0);
                end else begin
                    e = sb.pop_front();
                    if (e.kind == 0) begin
                        chk(mem_we && mem_addr == e.addr, {e.rq, " write addr"},
                            {39'h0, mem_we, mem_addr}, {39'h1, e.addr});
                        chk(mem_wdata == e.data, {e.rq, " write data"}, mem_wdata, e.data);
                    end else begin
                        chk(e.kind == 1 && !mem_we && mem_addr == e.addr, {e.rq, " read addr"},
                            {39'h0, mem_we, mem_addr}, {39'h0, e.addr});
                    end
                end
                if (mem_we) mem_model[mem_addr[7:3]] = mem_wdata;
                mem_rdata = mem_model[mem_addr[7:3]];
            end else begin
                mem_rdy = 1'b0;
                lat_cnt++;
            end
        end else begin
            mem_rdy = 1'b0;
            lat_cnt = 0;
        end
        if (rst_n && int_ack != '0) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected ack", {59'h0, int_ack}, 64'h0);
            end else begin
                e = sb.pop_front();
                chk(e.kind == 2 && int_ack == e.ack, {e.rq, " ack"},
                    {59'h0, int_ack}, {59'h0, e.ack});
                chk(psw_o == e.data, {e.rq, " new word"}, psw_o, e.data);
            end
            if (int_ack[0]) mchk_req = 1'b0;
            if (int_ack[1]) pgm_req = 1'b0;
            if (int_ack[2]) svc_req = 1'b0;
            if (int_ack[3]) ext_lines = '0;
            if (int_ack[4]) io_req = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] n1, n2, n3, nw, n4;
        n1 = 64'hFF00_0000_0000_1000 | sbit(13) | sbit(36) | sbit(32) | sbit(35)
             | (64'h5 << (63 - 11));
        n2 = sbit(3) | 64'h2000;
        n3 = sbit(6) | 64'h3000;
        nw = sbit(14) | 64'h4000;
        n4 = sbit(7) | 64'h5000;
        for (int i = 0; i < 32; i++) mem_model[i] = 64'h0;
        mem_model[8'h70 >> 3] = n1; mem_model[8'h68 >> 3] = n1;
        mem_model[8'h60 >> 3] = n1; mem_model[8'h58 >> 3] = n1;
        mem_model[8'h78 >> 3] = n1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(psw_o == 64'h0, "R1 reset word", psw_o, 64'h0);
        chk(!mem_req, "R1 no request", {63'h0, mem_req}, 64'h0);
        chk(int_ack == '0, "R1 no ack", {59'h0, int_ack}, 64'h0);

        // R4 fixed-overflow exception discarded under zero program mask
        expect_drop("R4 drop 08");
        pgm_code = 8'h08; pgm_req = 1'b1;
        settle();

        // R6 R7 supervisor call with its number as code
        expect_swap(2, 16'h002A, "R7 svc");
        svc_num = 8'h2A; svc_req = 1'b1;
        settle();
        chk(!wait_o, "R10 running", {63'h0, wait_o}, 64'h0);

        // R4 R8 enabled program exception keeps ILC and CC in saved word
        expect_swap(1, 16'h0008, "R8 pgm keep fields");
        pgm_code = 8'h08; pgm_req = 1'b1;
        settle();
        expect_drop("R4 drop 0A");
        pgm_code = 8'h0A; pgm_req = 1'b1;
        settle();
        expect_drop("R4 drop 0D");
        pgm_code = 8'h0D; pgm_req = 1'b1;
        settle();

        // R2 R9 all five at once, slow memory
        lat = 2;
        expect_swap(0, 16'hBEEF, "R2 mchk first");
        expect_swap(1, 16'h0001, "R2 pgm second");
        expect_swap(2, 16'h0007, "R2 svc third");
        expect_swap(3, 16'h0080, "R2 ext fourth");
        expect_swap(4, 16'h0100, "R2 io fifth");
        mchk_code = 16'hBEEF; mchk_req = 1'b1;
        pgm_code = 8'h01; pgm_req = 1'b1;
        svc_num = 8'h07; svc_req = 1'b1;
        ext_lines = 8'h80;
        io_dev = 16'h0100; io_req = 1'b1;
        settle();

        // R3 R5 channel enables
        lat = 1;
        mem_model[8'h60 >> 3] = n2; mem_model[8'h78 >> 3] = n2;
        expect_swap(2, 16'h0011, "R3 load ch3 enable");
        svc_num = 8'h11; svc_req = 1'b1;
        settle();
        expect_swap(4, 16'h0312, "R3 io ch3");
        io_dev = 16'h0312; io_req = 1'b1;
        settle();
        io_dev = 16'h0940; io_req = 1'b1;
        mchk_code = 16'h1234; mchk_req = 1'b1;
        idle_window(12, "R3 ch9 and mchk masked");
        mchk_req = 1'b0;
        mem_model[8'h60 >> 3] = n3; mem_model[8'h78 >> 3] = n3;
        expect_swap(2, 16'h0012, "R5 load high-channel enable");
        expect_swap(4, 16'h0940, "R5 pending io ch9");
        svc_num = 8'h12; svc_req = 1'b1;
        settle();

        // R10 wait state, R5 pending external, R7 external code
        lat = 0;
        mem_model[8'h60 >> 3] = nw;
        expect_swap(2, 16'h0013, "R10 enter wait");
        svc_num = 8'h13; svc_req = 1'b1;
        settle();
        chk(wait_o, "R10 wait set", {63'h0, wait_o}, 64'h1);
        ext_lines = 8'hC0;
        idle_window(12, "R10 quiet in wait");
        chk(wait_o, "R10 still waiting", {63'h0, wait_o}, 64'h1);
        mem_model[8'h60 >> 3] = n4; mem_model[8'h58 >> 3] = n4;
        expect_swap(2, 16'h0014, "R10 leave wait");
        expect_swap(3, 16'h00C0, "R7 ext timer and key");
        svc_num = 8'h14; svc_req = 1'b1;
        settle();
        chk(!wait_o, "R10 wait cleared", {63'h0, wait_o}, 64'h0);
        chk(sb.size() == 0, "R9 all events seen", 64'(sb.size()), 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule